// File: doc/BRIEF.md
# IR receive run-length encoder

This block watches the demodulated output of an infrared receiver and turns the waveform into a stream of one-byte run-length codes. A programmable divider of the system clock sets the sampling tick. The intended setting is one tick per 10 µs. The block measures each stretch of constant line level in ticks. When the level changes, it writes a byte that carries the polarity of the finished stretch and its length. A stretch longer than a 7-bit count can hold is split into full-length bytes. A line that stays idle therefore keeps producing saturated space bytes, and the host uses these to decide that reception has gone quiet.

The codes go into a small receive FIFO. A host reads the FIFO through a four-address register port, and the same port gives access to status, interrupt enables and control. The block flags bytes that are lost because the FIFO is full, and it raises an interrupt when data is waiting or when bytes have been lost. The host can switch reception off, invert the sense of the receiver input, and have reception blocked while the transmitter is sending.

Top module: `ir_rle_rx`

## Requirements
- R1: Each code byte holds the polarity of a run in bit 7, where 1 is a space (line level high after any inversion) and 0 is a pulse. Bits 6:0 hold the run length in ticks, from 1 to 127.
- R2: One tick occurs every `tickDiv`+1 clock cycles. Setting `tickDiv` to (clock frequency × 10 µs) − 1 makes one count equal 10 µs.
- R3: A run that reaches 127 ticks pushes a byte with length 127 (0x7F for a pulse, 0xFF for a space), and counting of that run continues from zero. A run whose length is an exact multiple of 127 pushes no further byte when it ends.
- R4: After reset or after reception is unblocked, nothing is pushed until the first level change. From then on, a continuous space pushes 0xFF once every 127 ticks.
- R5: Codes are read back in the order they were pushed, from register address 0. Each read of address 0 removes one byte. Reading address 0 while the FIFO is empty returns 0x00 and changes nothing. The FIFO holds DEPTH bytes (16 by default).
- R6: Status register (address 1) bit 0 is 1 exactly when the FIFO holds at least one byte.
- R7: A byte that arrives while the FIFO is full is dropped, and status bit 1 (overrun) is set. A read of the status register clears the overrun bit. The bytes already held are not changed.
- R8: `irq` is high when interrupt-enable register (address 2) bit 0 is set and data is available, or when its bit 2 is set and the overrun bit is set.
- R9: Control register (address 3) bit 5 set to 1 blocks reception. While it is set, no byte is pushed, and the run in progress is discarded.
- R10: Control bit 0 set to 1 inverts `irIn`, so that a high input counts as a pulse.
- R11: With control bit 1 set, reception is blocked while `txActive` is high, in the same way as in R9. With control bit 1 clear, `txActive` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irIn | input | 1 | Demodulated receiver line, high when no IR is present |
| txActive | input | 1 | High while the transmitter is sending |
| tickDiv | input | DIV_W | Clock cycles per tick minus one |
| regAddr | input | 2 | Register address: 0 data, 1 status, 2 interrupt enable, 3 control |
| regWr | input | 1 | Write strobe for addresses 2 and 3 |
| regRd | input | 1 | Read strobe; pops data at address 0 and clears overrun at address 1 |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the addressed register, valid in the same cycle |
| irq | output | 1 | Interrupt request |

## Verification
An error in the run counter or in the armed flag shows up in the value of the next byte read from address 0. Such a fault corrupts the code pushed at the next level change or at the next 127-tick boundary, so it appears a few cycles after the stimulus that caused it. A pointer or count error in the FIFO shows within one read: status bit 0 no longer matches the number of bytes pushed, or bytes come back out of order. A fault in the overrun flag or in the interrupt logic is visible on `irq` and on status bit 1 in the cycle after the dropped byte or the status read.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int LEN_W  = 7;
  localparam int CODE_W = LEN_W + 1;
  localparam int RUN_MAX = (1 << LEN_W) - 1;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IE   = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  localparam int CTL_INV  = 0;
  localparam int CTL_GATE = 1;
  localparam int CTL_DIS  = 5;
  localparam int IE_RX    = 0;
  localparam int IE_ERR   = 2;
  localparam int ST_AVAIL = 0;
  localparam int ST_OVR   = 1;

  localparam logic [7:0] CTL_MASK = 8'((1 << CTL_INV) | (1 << CTL_GATE) | (1 << CTL_DIS));
  localparam logic [7:0] IE_MASK  = 8'((1 << IE_RX) | (1 << IE_ERR));

  typedef struct packed {
    logic              push;
    logic [CODE_W-1:0] code;
    logic              pop;
    logic              statRd;
  } rle_strobe_t;
endpackage

// File: rtl/ir_rle_tick.sv
module ir_rle_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] tickDiv,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  assign tick = (divCnt >= tickDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // R2: with a nonzero divider, two ticks never fall on adjacent cycles
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && tickDiv != '0) |=> (!tick || tickDiv == '0));
endmodule

// File: rtl/ir_rle_ctrl.sv
module ir_rle_ctrl
  import ir_rle_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        irIn,
  input  logic        txActive,
  input  logic        tick,
  input  logic [1:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regWdata,
  output rle_strobe_t strobe,
  output logic [7:0]  ieReg,
  output logic [7:0]  ctlReg
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineLvl;
  logic                   blocked;
  logic                   armed;
  logic                   runLvl;
  logic [LEN_W-1:0]       runCnt;
  logic                   pushQ;
  logic [CODE_W-1:0]      codeQ;

  // input synchronizer, idle line is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], irIn};
  end

  assign lineLvl = syncQ[SYNC_STAGES-1] ^ ctlReg[CTL_INV];
  assign blocked = ctlReg[CTL_DIS] | (ctlReg[CTL_GATE] & txActive);

  // host-writable configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieReg  <= '0;
      ctlReg <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_IE)  ieReg  <= regWdata & IE_MASK;
      if (regAddr == ADDR_CTL) ctlReg <= regWdata & CTL_MASK;
    end
  end

  // run-length measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      runLvl <= 1'b1;
      runCnt <= '0;
      pushQ  <= 1'b0;
      codeQ  <= '0;
    end else begin
      pushQ <= 1'b0;
      if (blocked) begin
        armed  <= 1'b0;
        runLvl <= lineLvl;
        runCnt <= '0;
      end else if (tick) begin
        if (!armed) begin
          if (lineLvl != runLvl) begin
            armed  <= 1'b1;
            runLvl <= lineLvl;
            runCnt <= LEN_W'(1);
          end
        end else if (lineLvl == runLvl) begin
          if (runCnt == LEN_W'(RUN_MAX - 1)) begin
            pushQ  <= 1'b1;
            codeQ  <= {runLvl, LEN_W'(RUN_MAX)};
            runCnt <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          if (runCnt != '0) begin
            pushQ <= 1'b1;
            codeQ <= {runLvl, runCnt};
          end
          runLvl <= lineLvl;
          runCnt <= LEN_W'(1);
        end
      end
    end
  end

  assign strobe.push   = pushQ;
  assign strobe.code   = codeQ;
  assign strobe.pop    = regRd && (regAddr == ADDR_DATA);
  assign strobe.statRd = regRd && (regAddr == ADDR_STAT);

  // R9/R11: a blocked receiver pushes nothing in the following cycle
  p_blocked_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    blocked |=> !strobe.push);
  // R1: every pushed code carries a nonzero length
  p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (strobe.code[LEN_W-1:0] != '0));
  // R3: the live count never reaches the saturation value
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < LEN_W'(RUN_MAX));
endmodule

// File: rtl/ir_rle_dp.sv
module ir_rle_dp
  import ir_rle_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  rle_strobe_t strobe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  ieReg,
  input  logic [7:0]  ctlReg,
  output logic [7:0]  regRdata,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     fillCnt;
  logic              full, empty, doPush, doPop, ovr;

  assign full   = (fillCnt == CW'(DEPTH));
  assign empty  = (fillCnt == '0);
  assign doPush = strobe.push && !full;
  assign doPop  = strobe.pop && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= strobe.code;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // sticky loss flag; a fresh loss wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      ovr <= 1'b0;
    else if (strobe.push && full)   ovr <= 1'b1;
    else if (strobe.statRd)         ovr <= 1'b0;
  end

  always_comb begin
    case (regAddr)
      ADDR_DATA: regRdata = empty ? 8'h00 : 8'(mem[rdPtr]);
      ADDR_STAT: begin
        regRdata           = '0;
        regRdata[ST_AVAIL] = !empty;
        regRdata[ST_OVR]   = ovr;
      end
      ADDR_IE:   regRdata = ieReg;
      default:   regRdata = ctlReg;
    endcase
  end

  assign irq = (ieReg[IE_RX] & !empty) | (ieReg[IE_ERR] & ovr);

  // R7: a byte dropped on a full FIFO leaves the overrun bit set
  p_drop_sets_ovr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full) |=> ovr);
  // R7: a status read without a new loss leaves the bit clear
  p_stat_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.statRd && !(strobe.push && full)) |=> !ovr);
  // R5: occupancy stays within the FIFO depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CW'(DEPTH));
  // R5: an empty FIFO reads back as the no-activity code
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_DATA && empty) |-> (regRdata == 8'h00));
  // R8: enabled data-available always reaches the interrupt pin
  p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ieReg[IE_RX] && !empty) |-> irq);
endmodule

// File: rtl/ir_rle_rx.sv
module ir_rle_rx
  import ir_rle_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             irIn,
  input  logic             txActive,
  input  logic [DIV_W-1:0] tickDiv,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  output logic             irq
);
  logic        tick;
  rle_strobe_t strobe;
  logic [7:0]  ieReg;
  logic [7:0]  ctlReg;

  ir_rle_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rstN(rstN), .tickDiv(tickDiv), .tick(tick)
  );

  ir_rle_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .irIn(irIn), .txActive(txActive), .tick(tick),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .strobe(strobe), .ieReg(ieReg), .ctlReg(ctlReg)
  );

  ir_rle_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .ieReg(ieReg), .ctlReg(ctlReg), .regRdata(regRdata), .irq(irq)
  );
endmodule

// File: tb/ir_rle_rx_bench.sv
module ir_rle_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irIn = 1'b1;
  logic txActive = 1'b0;
  logic [DIV_W-1:0] tickDiv = '0;
  logic [1:0] regAddr = 2'd0;
  logic regWr = 1'b0;
  logic regRd = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic irq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_rle_rx #(.DIV_W(DIV_W)) u_ir_rle_rx (
    .clk(clk), .rstN(rstN), .irIn(irIn), .txActive(txActive), .tickDiv(tickDiv),
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic readExpect(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    regRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic drive(input logic lvl, input int n);
    irIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic stopRx();
    settle();
    regWrite(2'd3, 8'h20);
    drive(1'b1, 4);
  endtask

  task automatic startRx(input logic [7:0] ctl);
    regWrite(2'd3, ctl);
  endtask

  task automatic t_reset();
    drive(1'b1, 300);
    readExpect("R6 reset status", 2'd1, 8'h00);
    check("R8 reset irq", {7'b0, irq}, 8'h00);
    readExpect("R5 empty read", 2'd0, 8'h00);
    readExpect("R4 idle since reset, nothing pushed", 2'd1, 8'h00);
  endtask

  task automatic t_basic();
    drive(1'b0, 5); drive(1'b1, 10); drive(1'b0, 3); drive(1'b1, 20);
    stopRx();
    readExpect("R6 data available", 2'd1, 8'h01);
    readExpect("R1 pulse 5", 2'd0, 8'h05);
    readExpect("R1 space 10", 2'd0, 8'h8A);
    readExpect("R1 pulse 3", 2'd0, 8'h03);
    readExpect("R9 trailing run discarded", 2'd1, 8'h00);
    startRx(8'h00);
  endtask

  task automatic t_long();
    drive(1'b0, 300); drive(1'b1, 127); drive(1'b0, 4); drive(1'b1, 10);
    stopRx();
    readExpect("R3 first full pulse", 2'd0, 8'h7F);
    readExpect("R3 second full pulse", 2'd0, 8'h7F);
    readExpect("R3 pulse remainder", 2'd0, 8'h2E);
    readExpect("R3 exact 127 space", 2'd0, 8'hFF);
    readExpect("R3 no zero byte after exact run", 2'd0, 8'h04);
    readExpect("R3 drained", 2'd1, 8'h00);
    startRx(8'h00);
  endtask

  task automatic t_idle();
    drive(1'b0, 2); drive(1'b1, 260);
    regWrite(2'd3, 8'h20);
    drive(1'b1, 4);
    readExpect("R4 lead pulse", 2'd0, 8'h02);
    readExpect("R4 idle byte 1", 2'd0, 8'hFF);
    readExpect("R4 idle byte 2", 2'd0, 8'hFF);
    readExpect("R4 no third idle byte", 2'd1, 8'h00);
  endtask

  task automatic t_divider();
    tickDiv = 16'd3;
    drive(1'b1, 8);
    startRx(8'h00);
    drive(1'b1, 6);
    drive(1'b0, 24); drive(1'b1, 36); drive(1'b0, 8); drive(1'b1, 20);
    stopRx();
    readExpect("R2 pulse 6 ticks", 2'd0, 8'h06);
    readExpect("R2 space 9 ticks", 2'd0, 8'h89);
    readExpect("R2 pulse 2 ticks", 2'd0, 8'h02);
    tickDiv = 16'd0;
    drive(1'b1, 8);
  endtask

  task automatic t_invert();
    regWrite(2'd3, 8'h21);
    drive(1'b0, 8);
    startRx(8'h01);
    drive(1'b0, 4);
    drive(1'b1, 7); drive(1'b0, 12); drive(1'b1, 3); drive(1'b0, 10);
    settle();
    regWrite(2'd3, 8'h21);
    drive(1'b1, 8);
    regWrite(2'd3, 8'h20);
    readExpect("R10 inverted pulse", 2'd0, 8'h07);
    readExpect("R10 inverted space", 2'd0, 8'h8C);
    readExpect("R10 inverted pulse 3", 2'd0, 8'h03);
    readExpect("R10 drained", 2'd1, 8'h00);
  endtask

  task automatic t_disable();
    drive(1'b0, 6); drive(1'b1, 6); drive(1'b0, 6); drive(1'b1, 6);
    settle();
    readExpect("R9 disabled, nothing pushed", 2'd1, 8'h00);
    startRx(8'h00);
  endtask

  task automatic t_txgate();
    regWrite(2'd3, 8'h02);
    txActive = 1'b1;
    drive(1'b0, 5); drive(1'b1, 5); drive(1'b0, 5); drive(1'b1, 5);
    settle();
    readExpect("R11 gated during tx", 2'd1, 8'h00);
    txActive = 1'b0;
    drive(1'b1, 4);
    drive(1'b0, 5); drive(1'b1, 6);
    stopRx();
    readExpect("R11 reception after tx ends", 2'd0, 8'h05);
    startRx(8'h00);
    txActive = 1'b1;
    drive(1'b0, 9); drive(1'b1, 4);
    stopRx();
    txActive = 1'b0;
    readExpect("R11 gate off ignores txActive", 2'd0, 8'h09);
    readExpect("R11 drained", 2'd1, 8'h00);
    startRx(8'h00);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 2); drive(1'b1, 2);
    end
    stopRx();
    readExpect("R7 overrun and data", 2'd1, 8'h03);
    readExpect("R7 overrun cleared by read", 2'd1, 8'h01);
    for (int i = 0; i < 16; i++) begin
      readExpect("R7 held bytes intact", 2'd0, (i % 2 == 0) ? 8'h02 : 8'h82);
    end
    readExpect("R6 empty after drain", 2'd1, 8'h00);
    readExpect("R5 empty read after drain", 2'd0, 8'h00);
    startRx(8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    regWrite(2'd2, 8'h01);
    check("R8 no data no irq", {7'b0, irq}, 8'h00);
    drive(1'b0, 3); drive(1'b1, 3);
    stopRx();
    check("R8 rx irq", {7'b0, irq}, 8'h01);
    regWrite(2'd2, 8'h04);
    check("R8 rx masked", {7'b0, irq}, 8'h00);
    regRead(2'd0, d);
    startRx(8'h00);
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 2); drive(1'b1, 2);
    end
    stopRx();
    check("R8 error irq", {7'b0, irq}, 8'h01);
    regRead(2'd1, d);
    check("R8 error irq cleared", {7'b0, irq}, 8'h00);
    for (int i = 0; i < 16; i++) regRead(2'd0, d);
    regWrite(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_long();
    t_idle();
    t_divider();
    t_invert();
    t_disable();
    t_txgate();
    t_overrun();
    t_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0x00 expected 0x01");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule